// File: doc/BRIEF.md
# Run-of-Ones Moore Detector

This block watches a single-bit serial stream, sampled on each rising clock edge, and raises its output while the most recent RUN_LEN samples (three by default) have all been 1. It keeps a saturating count of trailing ones as its state. The output is decoded from that registered state alone, so a change on the input never reaches the output in the same cycle.

With the default RUN_LEN of 3 the machine has four states, held in two flip-flops with a plain binary code: zero ones seen (00), one (01), two (10), three or more (11). A 0 on the input from any state returns the machine to the zero-ones state. A 1 on the input in the top state keeps it there, so the output stays high for the whole of a long run. An asynchronous active-low reset forces the zero-ones state at once.

Top module: `ones_run_detector`

## Requirements
- R1: While rst_n is low, the state is 00 and y is 0. This holds immediately on reset assertion, without waiting for a clock edge.
- R2: On each rising clock edge with x=1, the state count goes up by one from 00 through 01 and 10 to 11.
- R3: On any rising clock edge with x=0, the next state is 00.
- R4: On a rising edge with x=1 while the state is 11, the state stays 11, so y stays high across a run of four or more ones.
- R5: y is 1 exactly when the state is 11, which with RUN_LEN=3 means the last three or more samples were 1. y does not change between clock edges when only x changes.
- R6: A run of exactly RUN_LEN-1 ones (two with the default) followed by a 0 never raises y.
- R7: The state is encoded in binary on ceil(log2(RUN_LEN+1)) flip-flops, and the encoding is the count of trailing ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x | input | 1 | Serial data input |
| y | output | 1 | High while the trailing run of ones is at least RUN_LEN |
| state | output | SW | Present state, the saturated count of trailing ones |

## Verification
The bench builds the detector with the default RUN_LEN of 3, giving the four-state binary machine. With that setting the complete transition table can be swept: every state is reached and then given each input value. Directed streams cover runs of exactly two, exactly three and more than three ones. A long pseudo-random stream is then compared cycle by cycle against a trailing-ones counter kept in the bench, and an extra check drives reset in the middle of a clock period.

// File: rtl/ones_run_detector.sv
module ones_run_detector #(
  parameter int RUN_LEN = 3,
  localparam int SW = $clog2(RUN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x,
  output logic          y,
  output logic [SW-1:0] state
);
  localparam logic [SW-1:0] TOP = SW'(RUN_LEN);

  logic [SW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!x)              cnt_d = '0;
    else if (cnt_q == TOP) cnt_d = TOP;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign state = cnt_q;
  assign y     = (cnt_q == TOP);

  p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> (state == '0 && !y));

  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (x && state != TOP) |=> state == $past(state) + 1'b1);

  p_zero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !x |=> state == '0);

  p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (x && y) |=> y);

  p_moore_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    y == (state == TOP));

  p_short_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(y) |-> $past(x));

  p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state <= TOP);
endmodule

// File: tb/tb_ones_run_detector.sv
module tb_ones_run_detector;
  localparam int RUN_LEN = 3;
  localparam int SW = $clog2(RUN_LEN + 1);

  logic clk = 0, rst_n = 0, x = 0;
  logic y;
  logic [SW-1:0] state;
  int checks = 0, errors = 0, ref_cnt = 0;
  bit done = 0;

  ones_run_detector #(.RUN_LEN(RUN_LEN)) dut (.clk, .rst_n, .x, .y, .state);

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive x mid-low phase, clock, then check after the edge
  task automatic step(bit b, string req);
    @(negedge clk); x = b;
    @(posedge clk);
    ref_cnt = b ? ((ref_cnt < RUN_LEN) ? ref_cnt + 1 : RUN_LEN) : 0;
    #5;
    chk({req, " state"}, state, ref_cnt);
    chk({req, " y"}, y, ref_cnt == RUN_LEN);
  endtask

  task automatic clear();
    step(0, "R3");
  endtask

  initial begin
    #1 chk("R1 reset y", y, 0);
    chk("R1 reset state", state, 0);
    #30 rst_n = 1;
    // R2 count up, R4 saturate
    for (int i = 0; i < 6; i++) step(1, i < 3 ? "R2" : "R4");
    clear();
    // R6 exactly two ones
    step(1, "R6"); step(1, "R6"); step(0, "R6");
    chk("R6 no y", y, 0);
    // exactly three
    step(1, "R5"); step(1, "R5"); step(1, "R5"); step(0, "R3");
    // R5: x toggles between edges without effect on y
    step(1, "R5"); step(1, "R5"); step(1, "R5");
    @(negedge clk); x = 0; #3;
    chk("R5 moore y stable", y, 1);
    x = 1; step(1, "R4");
    // R7 exhaustive transition sweep: reach each state, apply each input
    for (int s = 0; s <= RUN_LEN; s++)
      for (int b = 0; b < 2; b++) begin
        clear();
        for (int k = 0; k < s; k++) step(1, "R7");
        step(b[0], b ? "R2" : "R3");
      end
    // random stream
    for (int i = 0; i < 2000; i++) step($urandom_range(0, 3) != 0, "R5");
    // R1 async reset mid-period
    step(1, "R2"); step(1, "R2"); step(1, "R2");
    @(negedge clk); #2 rst_n = 0; #1;
    chk("R1 async y", y, 0);
    chk("R1 async state", state, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule